// File: doc/BRIEF.md
# Reference Edge Divider with Optional Doubling

This block produces the reference pulse for a phase detector. A reference waveform arrives unrelated to the fast system clock. The block resynchronizes it and finds its edges. It then counts the edges it treats as active and raises a single-cycle pulse on every R-th one. When doubling is off, only falling reference edges count. When doubling is on, every transition counts, so for a given R the pulse rate is twice as high.

The divide ratio R is a 4-bit value from 1 to 15. A value of 0 is handled as 1. A new R is not used in the middle of a count period. It is taken up when a period starts: after reset, while the counter is held, and at each terminal count. A counter-reset control and a power-down control both hold the counter in its load state.

Top module: `ref_edge_divider`

## Requirements
- R1: After rst_n is deasserted, ref_pulse is 0 and the edge count starts from zero.
- R2: With dbl_en = 0, only a high-to-low change of ref_in counts. Rising changes have no effect on the count.
- R3: With dbl_en = 1, both a low-to-high and a high-to-low change of ref_in count as an edge.
- R4: ref_pulse is 1 for exactly one clk cycle on every R-th counted edge. It rises on the third rising clk edge after the ref_in change that completes the count.
- R5: An r_div value of 0 divides by 1, so every counted edge produces a pulse.
- R6: While cnt_rst = 1, no edge is counted and ref_pulse stays 0. Once cnt_rst returns to 0, counting restarts from zero.
- R7: pwr_dn = 1 has the same hold effect as cnt_rst: no pulse, and counting restarts from zero on release.
- R8: If r_div changes in the middle of a count period, the period in progress finishes with the old ratio. The new ratio applies from the next period on.
- R9: Every ratio from 1 to 15, including the maximum 15, yields exactly one pulse per R counted edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock that samples the reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference waveform, asynchronous to clk |
| dbl_en | input | 1 | 1 counts both edges, 0 counts falling edges only |
| r_div | input | 4 | Divide ratio; 0 is handled as 1 |
| cnt_rst | input | 1 | Holds the counter in its load state |
| pwr_dn | input | 1 | Power-down; holds the counter in its load state |
| ref_pulse | output | 1 | One-cycle reference pulse |

## Verification
The reference toggles in long runs under several combinations of ratio and doubling setting. Each combination includes ratio 1, the zero ratio, a mid-range ratio and the maximum ratio 15. Comparing the pulse counts for the same toggle count with doubling off and on shows whether rising edges are counted. Comparing across ratios shows whether division is correct. The timing of each pulse is checked on every edge, so a wrong pipeline depth or a pulse wider than one cycle stands out. Directed runs then do three things:
- hold the counter in the middle of a period with each hold control, to separate a true restart from a resumed count;
- change the ratio in the middle of a period, to show when the new ratio is taken up;
- check the reset state.

// File: rtl/ref_edge_divider.sv
module ref_edge_divider #(
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_in,
  input  logic          dbl_en,
  input  logic [RW-1:0] r_div,
  input  logic          cnt_rst,
  input  logic          pwr_dn,
  output logic          ref_pulse
);

  logic [2:0]    sh;
  logic          rise, fall, hit, hold, tc, armed;
  logic [RW-1:0] r_eff, cnt, r_act;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], ref_in};

  assign rise  = sh[1] & ~sh[2];
  assign fall  = ~sh[1] & sh[2];
  assign hit   = fall | (dbl_en & rise);
  assign hold  = cnt_rst | pwr_dn;
  assign r_eff = (r_div == '0) ? RW'(1) : r_div;
  assign tc    = (cnt == r_act - RW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      r_act     <= RW'(1);
      armed     <= 1'b0;
      ref_pulse <= 1'b0;
    end else begin
      armed     <= 1'b1;
      ref_pulse <= 1'b0;
      if (hold || !armed) begin
        cnt   <= '0;
        r_act <= r_eff;
      end else if (hit) begin
        if (tc) begin
          cnt       <= '0;
          r_act     <= r_eff;
          ref_pulse <= 1'b1;
        end else begin
          cnt <= cnt + RW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/ref_edge_divider_chk.sv
module ref_edge_divider_chk #(
  parameter int RW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_in,
  input logic          dbl_en,
  input logic [RW-1:0] r_div,
  input logic          cnt_rst,
  input logic          pwr_dn,
  input logic          ref_pulse
);

  logic [2:0] age;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;

  assign warm = (age >= 3'd5);

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rst || pwr_dn) |=> !ref_pulse); // R6 R7

  AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && ref_pulse && !$past(dbl_en)) |-> ($past(ref_in, 4) && !$past(ref_in, 3))); // R2

  AST_PULSE_HAS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && ref_pulse) |-> ($past(ref_in, 4) != $past(ref_in, 3))); // R3

  AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pulse && !dbl_en) |=> !ref_pulse); // R4

  always_comb
    if (rst_n && !warm) AST_RESET_QUIET: assert (!ref_pulse || age >= 3'd3); // R1

  logic unused_ok;
  assign unused_ok = ^r_div;

endmodule

bind ref_edge_divider ref_edge_divider_chk #(.RW(RW)) u_chk (.*);

// File: tb/ref_edge_divider_bench.sv
module ref_edge_divider_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_in = 1'b0;
  logic       dbl_en = 1'b0;
  logic [3:0] r_div = 4'd1;
  logic       cnt_rst = 1'b0;
  logic       pwr_dn = 1'b0;
  logic       ref_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ref_edge_divider u_ref_edge_divider (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .dbl_en(dbl_en),
    .r_div(r_div), .cnt_rst(cnt_rst), .pwr_dn(pwr_dn), .ref_pulse(ref_pulse)
  );

  localparam int NV = 8;
  localparam int V_DBL[NV] = '{0, 0, 1, 1, 0, 1, 1, 0};
  localparam int V_R  [NV] = '{1, 3, 3, 5, 0, 15, 1, 15};
  localparam int V_TGL[NV] = '{8, 12, 12, 11, 6, 30, 7, 60};
  localparam int V_EXP[NV] = '{4, 2, 4, 2, 3, 2, 7, 2};

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Toggle ref_in, then watch four cycles; pulse may appear only at the third.
  task automatic toggle(output logic got);
    int stray = 0;
    @(negedge clk) ref_in = ~ref_in;
    got = 1'b0;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (i == 3) got = ref_pulse;
      else if (ref_pulse) stray++;
    end
    if (stray != 0) check("R4 pulse timing", stray, 0);
  endtask

  task automatic restart();
    @(negedge clk) cnt_rst = 1'b1; ref_in = 1'b0;
    repeat (4) @(negedge clk);
    cnt_rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_seq(input string req, input int n, input logic [15:0] pat);
    logic g;
    for (int i = 0; i < n; i++) begin
      toggle(g);
      check(req, int'(g), int'(pat[i]));
    end
  endtask

  initial begin
    logic g;
    int   np;
    repeat (3) @(negedge clk);
    check("R1 pulse low in reset", int'(ref_pulse), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 pulse low after reset", int'(ref_pulse), 0);

    // R1: count starts from zero: R=2 doubled, pulse on second edge
    dbl_en = 1'b1; r_div = 4'd2;
    restart();
    expect_seq("R1 first period from zero", 4, 16'b1010);

    // Vector table: R2 R3 R5 R9
    for (int v = 0; v < NV; v++) begin
      dbl_en = V_DBL[v][0];
      r_div  = V_R[v][3:0];
      restart();
      np = 0;
      for (int t = 0; t < V_TGL[v]; t++) begin
        toggle(g);
        np += int'(g);
      end
      check($sformatf("R2/R3 R9 vector %0d", v), np, V_EXP[v]);
      if (V_R[v] == 0) check("R5 zero ratio", np, V_EXP[v]);
    end

    // R2: rising edge alone yields nothing at R=1
    dbl_en = 1'b0; r_div = 4'd1;
    restart();
    expect_seq("R2 rise ignored, fall counted", 2, 16'b10);

    // R6: hold mid-period, then restart from zero
    dbl_en = 1'b1; r_div = 4'd3;
    restart();
    expect_seq("R6 before hold", 2, 16'b00);
    @(negedge clk) cnt_rst = 1'b1;
    expect_seq("R6 no pulse while held", 4, 16'b0000);
    @(negedge clk) cnt_rst = 1'b0;
    @(negedge clk);
    expect_seq("R6 restart from zero", 3, 16'b100);

    // R7: power-down behaves the same
    restart();
    expect_seq("R7 before power-down", 2, 16'b00);
    @(negedge clk) pwr_dn = 1'b1;
    expect_seq("R7 no pulse while powered down", 3, 16'b000);
    @(negedge clk) pwr_dn = 1'b0;
    @(negedge clk);
    expect_seq("R7 restart from zero", 3, 16'b100);

    // R8: change ratio mid-period, old one finishes
    r_div = 4'd4;
    restart();
    expect_seq("R8 old ratio start", 2, 16'b00);
    r_div = 4'd2;
    expect_seq("R8 old ratio completes", 2, 16'b10);
    expect_seq("R8 new ratio applies", 4, 16'b1010);

    // R9: maximum ratio exact boundary
    dbl_en = 1'b1; r_div = 4'd15;
    restart();
    np = 0;
    for (int t = 0; t < 14; t++) begin toggle(g); np += int'(g); end
    check("R9 no pulse before 15th edge", np, 0);
    toggle(g);
    check("R9 pulse on 15th edge", int'(g), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule